// File: doc/BRIEF.md
# CAN Bus-Off Recovery Monitor

This block follows a CAN node through its recovery from the bus-off fault condition. While the node is bus-off, the monitor looks at one sampled bus level per nominal bit time and counts runs of consecutive recessive bits. Each completed run of eleven recessive bits raises the transmit error counter by one. When that counter reaches 128, the node returns to error-active and both error counters are cleared. A dominant bit in the middle of a run throws away only the partial run. Runs that were already completed stay counted.

The error-management logic pulses `boff_enter` to put the node into bus-off. The bit-timing logic drives `bit_stb` once per bit time, with `bit_rcv` carrying the sampled level (1 = recessive). The state machine has three named states, `FC_ACTIVE` (2'b00), `FC_PASSIVE` (2'b01) and `FC_BUSOFF` (2'b10), and it reports the current one on `fc_state`. The transitions are:
- **enter**: `boff_enter` moves any state to `FC_BUSOFF`.
- **recover**: `FC_BUSOFF` moves to `FC_ACTIVE` on the clock after the transmit counter reads 128.
- **hold**: every other cycle keeps the current state.

This block only recovers the node, so it never enters `FC_PASSIVE`. Ordinary increments of the receive counter belong to other logic, so `rec_cnt` here only shows the cleared value. On an idle bus, recovery takes 1408 strobes plus one clock.

Top module: `can_busoff_recovery`

## Requirements
- R1: After a synchronous reset, `fc_state` is 2'b00, `tec_cnt` and `rec_cnt` are 0 and `recov_done` is 0.
- R2: A `boff_enter` pulse, in any state and even in the middle of a recovery, makes `fc_state` 2'b10 on the next clock, with `tec_cnt` 0 and the partial run discarded.
- R3: In bus-off, a strobe with `bit_rcv`=1 extends the current run. The strobe that completes the eleventh consecutive recessive bit starts a new run and raises `tec_cnt` by one.
- R4: In bus-off, a strobe with `bit_rcv`=0 discards the partial run and leaves `tec_cnt` unchanged.
- R5: On cycles with `bit_stb`=0, the level on `bit_rcv` has no effect on any count.
- R6: The clock after `tec_cnt` reads 128 in bus-off sets `fc_state` to 2'b00 and clears `tec_cnt` and `rec_cnt` to 0.
- R7: `recov_done` is high for exactly the first clock cycle back in error-active and low at all other times.
- R8: Outside bus-off, strobes do not change `tec_cnt`.
- R9: `tec_cnt` never exceeds 128.
- R10: On a bus that stays recessive, recovery completes on the clock after the 1408th strobe that follows the entry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe, once per nominal bit time |
| bit_rcv | input | 1 | Sampled bus level, 1 = recessive |
| boff_enter | input | 1 | Bus-off entry pulse |
| fc_state | output | 2 | Fault-confinement state: 00 active, 01 passive, 1x bus-off |
| tec_cnt | output | 9 | Transmit error counter |
| rec_cnt | output | 9 | Receive error counter |
| recov_done | output | 1 | One-cycle pulse when recovery completes |

## Verification
The run counter is internal, so a partial run shows up at the ports only through its effect on when `tec_cnt` next steps. The stimulus first breaks a run with a dominant bit or an entry pulse. It then supplies fewer recessive bits than a surviving partial run would need to wrap, and checks that the counter has not moved. Reaching the 128 boundary takes 1408 recessive strobes. The bench drives all of them and checks the counter one strobe short of the limit, at the limit, and on the clock of the transition.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_t;
endpackage

// File: rtl/bor_run_cnt.sv
module bor_run_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       en,
    input  logic                       stb,
    input  logic                       lvl,
    output logic [$clog2(RUN_LEN)-1:0] run,
    output logic                       wrap
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run_q;

    assign wrap = en && stb && lvl && (run_q == LAST);
    assign run  = run_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (en && stb) begin
            if (!lvl || wrap) run_q <= '0;
            else              run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/bor_tec_cnt.sv
module bor_tec_cnt #(
    parameter int TEC_W     = 9,
    parameter int TEC_LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [TEC_W-1:0] tec,
    output logic             full
);
    localparam logic [TEC_W-1:0] LIM = TEC_W'(TEC_LIMIT);

    logic [TEC_W-1:0] tec_q;

    assign tec  = tec_q;
    assign full = (tec_q == LIM);

    always_ff @(posedge clk) begin
        if (rst || clr)         tec_q <= '0;
        else if (inc && !full)  tec_q <= tec_q + 1'b1;
    end
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
    import can_bor_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int TEC_LIMIT = 128,
    parameter int TEC_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             bit_rcv,
    input  logic             boff_enter,
    output logic [1:0]       fc_state,
    output logic [TEC_W-1:0] tec_cnt,
    output logic [TEC_W-1:0] rec_cnt,
    output logic             recov_done
);
    localparam int RUN_W = $clog2(RUN_LEN);

    fc_state_t        state_q, state_d;
    logic             done_q;
    logic             tec_full;
    logic             run_wrap;
    logic             count_en;
    logic             leave;
    logic             cnt_clr;
    logic [RUN_W-1:0] run_cnt;

    // Counting runs only while bus-off and short of the limit.
    assign count_en = (state_q == FC_BUSOFF) && !tec_full;
    assign leave    = (state_q == FC_BUSOFF) && tec_full && !boff_enter;
    assign cnt_clr  = boff_enter || leave;

    bor_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .en   (count_en),
        .stb  (bit_stb),
        .lvl  (bit_rcv),
        .run  (run_cnt),
        .wrap (run_wrap)
    );

    bor_tec_cnt #(.TEC_W(TEC_W), .TEC_LIMIT(TEC_LIMIT)) u_tec (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (run_wrap),
        .tec  (tec_cnt),
        .full (tec_full)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE:  if (boff_enter) state_d = FC_BUSOFF;
            FC_PASSIVE: if (boff_enter) state_d = FC_BUSOFF;
            FC_BUSOFF:  if (leave)      state_d = FC_ACTIVE;
            default:                    state_d = FC_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FC_ACTIVE;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= leave;
    end

    assign fc_state   = state_q;
    assign recov_done = done_q;
    assign rec_cnt    = '0;
endmodule

// File: rtl/can_bor_checker.sv
module can_bor_checker #(
    parameter int TEC_W     = 9,
    parameter int TEC_LIMIT = 128,
    parameter int RUN_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_stb,
    input logic             bit_rcv,
    input logic             boff_enter,
    input logic [1:0]       fc_state,
    input logic [TEC_W-1:0] tec_cnt,
    input logic [TEC_W-1:0] rec_cnt,
    input logic             recov_done,
    input logic [RUN_W-1:0] run_cnt
);
    localparam logic [TEC_W-1:0] LIM = TEC_W'(TEC_LIMIT);

    p_tec_bound_r9: assert property (@(posedge clk) disable iff (rst)
        tec_cnt <= LIM);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        recov_done |=> !recov_done);

    p_done_active_r6: assert property (@(posedge clk) disable iff (rst)
        recov_done |-> (fc_state == 2'b00 && tec_cnt == '0 && rec_cnt == '0));

    p_entry_r2: assert property (@(posedge clk) disable iff (rst)
        boff_enter |=> (fc_state[1] && tec_cnt == '0 && run_cnt == '0));

    p_recover_r6: assert property (@(posedge clk) disable iff (rst)
        (fc_state[1] && tec_cnt == LIM && !boff_enter) |=> (fc_state == 2'b00 && recov_done));

    p_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && !boff_enter && fc_state[1] && tec_cnt != LIM)
            |=> ($stable(tec_cnt) && $stable(run_cnt)));

    p_dominant_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !bit_rcv && !boff_enter && fc_state[1] && tec_cnt != LIM)
            |=> (run_cnt == '0 && $stable(tec_cnt)));

    p_active_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fc_state == 2'b00 && !boff_enter) |=> (tec_cnt == '0));
endmodule

bind can_busoff_recovery can_bor_checker #(
    .TEC_W(TEC_W), .TEC_LIMIT(TEC_LIMIT), .RUN_W(RUN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .bit_rcv    (bit_rcv),
    .boff_enter (boff_enter),
    .fc_state   (fc_state),
    .tec_cnt    (tec_cnt),
    .rec_cnt    (rec_cnt),
    .recov_done (recov_done),
    .run_cnt    (run_cnt)
);

// File: tb/sim_can_busoff_recovery.sv
module sim_can_busoff_recovery;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       bit_rcv = 1'b1;
    logic       boff_enter = 1'b0;
    logic [1:0] fc_state;
    logic [8:0] tec_cnt;
    logic [8:0] rec_cnt;
    logic       recov_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    can_busoff_recovery u0 (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_rcv(bit_rcv),
        .boff_enter(boff_enter), .fc_state(fc_state), .tec_cnt(tec_cnt),
        .rec_cnt(rec_cnt), .recov_done(recov_done)
    );

    // Vector table: recessive strobes, then optional dominant strobe, expected TEC
    localparam int NV = 11;
    localparam int V_REC [NV] = '{11, 10, 5, 6, 22, 3, 11, 0, 11, 11, 9};
    localparam int V_DOM [NV] = '{ 0,  1, 0, 0,  0, 1,  0, 1,  1,  0, 1};
    localparam int V_TEC [NV] = '{ 1,  1, 1, 2,  4, 4,  5, 5,  6,  7, 7};

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(logic s, logic l, logic b);
        bit_stb = s; bit_rcv = l; boff_enter = b;
        @(posedge clk);
        #2;
        bit_stb = 1'b0; bit_rcv = 1'b1; boff_enter = 1'b0;
    endtask

    // Strobe followed by an idle cycle carrying the opposite level (R5)
    task automatic rec_bit();
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
    endtask

    task automatic dom_bit();
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        rst = 1'b0;
        // R1 reset state
        chk("R1 state", fc_state, 0);
        chk("R1 tec", tec_cnt, 0);
        chk("R1 rec", rec_cnt, 0);
        chk("R1 done", recov_done, 0);

        // R8 strobes while active do nothing
        for (int i = 0; i < 15; i++) rec_bit();
        chk("R8 tec active", tec_cnt, 0);

        // R2 entry
        tick(1'b0, 1'b1, 1'b1);
        chk("R2 state", fc_state, 2);
        chk("R2 tec", tec_cnt, 0);

        // Vector walk: R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < V_REC[v]; k++) rec_bit();
            if (V_DOM[v] != 0) dom_bit();
            chk(V_DOM[v] != 0 ? "R4 vec tec" : "R3 vec tec", tec_cnt, V_TEC[v]);
        end
        chk("R5 still busoff", fc_state, 2);

        // R2 restart mid-recovery discards partial run
        for (int k = 0; k < 7; k++) rec_bit();
        tick(1'b0, 1'b1, 1'b1);
        chk("R2 restart tec", tec_cnt, 0);
        for (int k = 0; k < 4; k++) rec_bit();
        chk("R2 run cleared", tec_cnt, 0);
        for (int k = 0; k < 7; k++) rec_bit();
        chk("R3 after restart", tec_cnt, 1);

        // R10 full idle-bus recovery
        tick(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 1407; k++) rec_bit();
        chk("R10 tec before limit", tec_cnt, 127);
        chk("R10 still busoff", fc_state, 2);
        tick(1'b1, 1'b1, 1'b0);
        chk("R9 tec at limit", tec_cnt, 128);
        chk("R7 no early done", recov_done, 0);
        tick(1'b1, 1'b1, 1'b0);
        chk("R6 state active", fc_state, 0);
        chk("R6 tec cleared", tec_cnt, 0);
        chk("R6 rec cleared", rec_cnt, 0);
        chk("R7 done high", recov_done, 1);
        tick(1'b0, 1'b1, 1'b0);
        chk("R7 done low", recov_done, 0);
        for (int k = 0; k < 12; k++) rec_bit();
        chk("R8 tec after recovery", tec_cnt, 0);

        // R1 reset during bus-off
        tick(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 11; k++) rec_bit();
        rst = 1'b1;
        tick(1'b0, 1'b1, 1'b0);
        rst = 1'b0;
        chk("R1 reset state", fc_state, 0);
        chk("R1 reset tec", tec_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule